// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits on the host side of a byte-wide asynchronous static RAM. It takes one read or write request at a time from a valid/ready interface. For each request it produces the active-low chip enable, output enable and write enable strobes, the address, and the write data with its tri-state enable. Reads return the sampled byte together with a one-cycle done pulse. Writes also end with a done pulse.

Every timing interval is a parameter counted in clock cycles:

- `T_AA`: address-to-data access time.
- `T_OA`: output-enable-to-data access time.
- `T_WP`: write strobe width.
- `T_DS`: data setup before the write strobe rises.
- `T_DH`: data hold after the write strobe rises.
- `T_REC`: minimum time the enables stay high between cycles.
- `T_CYC`: common minimum length for read and write cycles.

A sequencer steps through fixed phases and reloads a single down counter on each phase change. The data pins are split into an output bus, an input bus and a drive enable, so that the pad ring can build the bidirectional pin.

Top module: `asram_ctrl`

## Requirements
- R1: The address is registered when a request is accepted. It does not change while chip enable is low, nor during the recovery gap. It changes only at the next accepted request, and only while chip enable is high.
- R2: A write first lowers chip enable for one cycle with write enable still high. It then holds write enable low for exactly T_WP cycles. Write enable rises while chip enable is still low, and chip enable stays low for T_DH more cycles.
- R3: Output enable stays high on every cycle of a write.
- R4: The write data bus is driven (drive enable = 1) for exactly the last T_DS cycles of the write strobe and the T_DH cycles after it, and is released at all other times. It is never driven while output enable is low. The byte that is driven is the byte that was requested.
- R5: A read lowers chip enable and output enable together, one cycle after the address is presented. It samples the data bus at the first clock edge at which the address has been valid for at least T_AA cycles and output enable has been low for at least T_OA cycles.
- R6: `done` is a single-cycle pulse in the cycle after the active part of a request ends. For reads, `rd_data` holds the sampled byte from that cycle until the next read completes.
- R7: After the active part, both enables stay high for at least T_REC cycles. `req_ready` is low for exactly max(active + T_REC, T_CYC) cycles after acceptance. The active part is 2 + T_WP + T_DH cycles for a write and 1 + max(T_AA-1, T_OA) cycles for a read.
- R8: `req_ready` is high only when the controller is idle. A request held valid while `req_ready` is low has no effect on the memory.
- R9: During reset all three strobes are high, the data bus is released, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last byte read |
| sram_addr | output | ADDR_W | Address to memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | DATA_W | Data driven toward memory |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | DATA_W | Data returned by memory |

## Verification
The bench models the memory at the pins. Its memory returns a poison byte until both the address and the output-enable access windows are met, so a controller that samples one cycle early reads the wrong value. A controller that raises chip enable together with write enable, or that shortens the setup or hold windows, either leaves the model memory unwritten or trips the model's width counters. The bench uses back-to-back requests and a request held while busy to expose a wrong recovery length or an accept that should have been ignored. Read-after-write to the same address catches a write that stored the wrong byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_RACC,
    PH_WSET,
    PH_WPUL,
    PH_WHLD,
    PH_RECV
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles with output enable low before the read sample edge
  function automatic int rd_wait(input int t_aa, input int t_oa);
    return max2(t_aa - 1, t_oa);
  endfunction

  function automatic int active_len(input bit wr, input int t_aa, input int t_oa,
                                    input int t_wp, input int t_dh);
    return wr ? (2 + t_wp + t_dh) : (1 + rd_wait(t_aa, t_oa));
  endfunction

  function automatic int recov_len(input int act, input int t_rec, input int t_cyc);
    return max2(t_rec, t_cyc - act);
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CW    = 5,
  parameter int T_AA  = 4,
  parameter int T_OA  = 2,
  parameter int T_WP  = 3,
  parameter int T_DS  = 2,
  parameter int T_DH  = 1,
  parameter int T_REC = 2,
  parameter int T_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] cnt,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          wr_end,
  output logic          wr_done,
  output logic          rd_capture,
  output logic          drive,
  output logic          ready,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n
);

  localparam int RWAIT = rd_wait(T_AA, T_OA);
  localparam int RACT  = active_len(1'b0, T_AA, T_OA, T_WP, T_DH);
  localparam int WACT  = active_len(1'b1, T_AA, T_OA, T_WP, T_DH);
  localparam int RREC  = recov_len(RACT, T_REC, T_CYC);
  localparam int WREC  = recov_len(WACT, T_REC, T_CYC);

  phase_e phase, phase_nx;
  logic   is_wr;
  logic   last;

  assign last = (cnt == '0);

  always_comb begin
    phase_nx = phase;
    load     = 1'b0;
    load_val = '0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        phase_nx = PH_ADDR;
        load     = 1'b1;
      end
      PH_ADDR: if (last) begin
        load = 1'b1;
        if (is_wr) phase_nx = PH_WSET;
        else begin
          phase_nx = PH_RACC;
          load_val = CW'(RWAIT - 1);
        end
      end
      PH_WSET: if (last) begin
        phase_nx = PH_WPUL;
        load     = 1'b1;
        load_val = CW'(T_WP - 1);
      end
      PH_WPUL: if (last) begin
        phase_nx = PH_WHLD;
        load     = 1'b1;
        load_val = CW'(T_DH - 1);
      end
      PH_WHLD: if (last) begin
        phase_nx = PH_RECV;
        load     = 1'b1;
        load_val = CW'(WREC - 1);
      end
      PH_RACC: if (last) begin
        phase_nx = PH_RECV;
        load     = 1'b1;
        load_val = CW'(RREC - 1);
      end
      PH_RECV: if (last) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      is_wr <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (accept) is_wr <= req_write;
    end
  end

  assign ready      = (phase == PH_IDLE);
  assign accept     = ready && req_valid;
  assign wr_end     = (phase == PH_WPUL) && last;
  assign wr_done    = (phase == PH_WHLD) && last;
  assign rd_capture = (phase == PH_RACC) && last;
  assign drive      = ((phase == PH_WPUL) && (cnt < CW'(T_DS))) || (phase == PH_WHLD);
  assign ce_n       = !((phase == PH_WSET) || (phase == PH_WPUL) ||
                        (phase == PH_WHLD) || (phase == PH_RACC));
  assign oe_n       = !(phase == PH_RACC);
  assign we_n       = !(phase == PH_WPUL);

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= rd_capture || wr_done;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_capture) rdata_q <= dq_in;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int T_AA   = 4,
  parameter int T_OA   = 2,
  parameter int T_WP   = 3,
  parameter int T_DS   = 2,
  parameter int T_DH   = 1,
  parameter int T_REC  = 2,
  parameter int T_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int SPAN = T_CYC + T_WP + T_AA + T_OA + T_DH + T_REC + 2;
  localparam int CW   = $clog2(SPAN + 1);

  if (T_AA < 1 || T_OA < 1 || T_WP < 1 || T_DS < 1 || T_DH < 1 ||
      T_REC < 1 || T_CYC < 1) begin : g_bad_timing
    $error("asram_ctrl: every timing parameter must be at least one cycle");
  end
  if (T_DS > T_WP) begin : g_bad_setup
    $error("asram_ctrl: data setup cannot exceed the write strobe width");
  end

  logic          load;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          wr_end;
  logic          wr_done;
  logic          rd_capture;
  logic          drive;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt)
  );

  asram_seq #(
    .CW(CW), .T_AA(T_AA), .T_OA(T_OA), .T_WP(T_WP), .T_DS(T_DS),
    .T_DH(T_DH), .T_REC(T_REC), .T_CYC(T_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .cnt        (cnt),
    .load       (load),
    .load_val   (load_val),
    .accept     (accept),
    .wr_end     (wr_end),
    .wr_done    (wr_done),
    .rd_capture (rd_capture),
    .drive      (drive),
    .ready      (req_ready),
    .ce_n       (sram_ce_n),
    .oe_n       (sram_oe_n),
    .we_n       (sram_we_n)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_capture (rd_capture),
    .wr_done    (wr_done),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .dq_in      (sram_dq_in),
    .addr_q     (sram_addr),
    .wdata_q    (sram_dq_out),
    .rdata_q    (rd_data),
    .done_q     (done)
  );

  assign sram_dq_oe = drive;

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              wr_end,
  input logic              rd_capture
);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> $stable(sram_addr)); // R1

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n); // R2

  AST_WE_RISES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> (sram_we_n && !sram_ce_n && sram_dq_oe)); // R2

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R3

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R4

  AST_SAMPLE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!sram_oe_n && !sram_ce_n)); // R5

  AST_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> done); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && !sram_dq_oe)); // R8

endmodule

bind asram_ctrl asram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_dq_oe (sram_dq_oe),
  .sram_addr  (sram_addr),
  .wr_end     (wr_end),
  .rd_capture (rd_capture)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int AW = 11, DW = 8;
  localparam int T_AA = 4, T_OA = 2, T_WP = 3, T_DS = 2, T_DH = 1, T_REC = 2, T_CYC = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, ce_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out;
  logic [DW-1:0] dq_in = 8'hEE;
  logic [AW-1:0] sram_addr;

  always #2.5 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_AA(T_AA), .T_OA(T_OA), .T_WP(T_WP),
               .T_DS(T_DS), .T_DH(T_DH), .T_REC(T_REC), .T_CYC(T_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .sram_addr(sram_addr), .sram_ce_n(ce_n),
    .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_dq_out(dq_out), .sram_dq_oe(dq_oe),
    .sram_dq_in(dq_in));

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int busy_cycles(input bit wr);
    int act;
    act = wr ? (T_WP + T_DH + 2) : (mx(T_OA, T_AA - 1) + 1);
    return mx(act + T_REC, T_CYC);
  endfunction

  // memory model at the pins, and independent expectation
  logic [DW-1:0] pin_mem [DEPTH];
  logic [DW-1:0] exp_mem [DEPTH];
  typedef struct { bit wr; logic [DW-1:0] data; } item_t;
  item_t sb[$];

  logic [AW-1:0] prev_addr = '0;
  bit prev_we_n = 1'b1, prev_ce_n = 1'b1;
  int ast = 0, olc = 0, wlow = 0, sc = 0, hc = 0;
  bit in_hold = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (!ce_n && !prev_ce_n && sram_addr != prev_addr)
      check(1'b0, "R1 address moved under chip enable", sram_addr, prev_addr);
    if (!we_n && !oe_n) check(1'b0, "R3 oe low during write", 0, 1);
    if (!we_n && ce_n) check(1'b0, "R2 we low without ce", 1, 0);
    if (dq_oe && !oe_n) check(1'b0, "R4 drive while oe low", 1, 0);
    if (!we_n && prev_we_n && prev_ce_n) check(1'b0, "R2 ce must fall before we", 1, 0);
    ast = (sram_addr == prev_addr) ? ast + 1 : 1;
    olc = (!ce_n && !oe_n) ? olc + 1 : 0;
    if (!we_n) begin
      wlow++;
      sc = dq_oe ? sc + 1 : 0;
    end
    if (in_hold) begin
      if (dq_oe) hc++;
      else begin
        check(hc == T_DH, "R4 hold window", hc, T_DH);
        in_hold = 1'b0;
      end
    end
    if (we_n && !prev_we_n) begin
      check(wlow == T_WP, "R2 write strobe width", wlow, T_WP);
      check(sc == T_DS, "R4 setup window", sc, T_DS);
      check(!ce_n, "R2 ce still low at we rise", ce_n, 0);
      if (!ce_n && dq_oe) pin_mem[sram_addr] = dq_out;
      hc = dq_oe ? 1 : 0;
      in_hold = 1'b1;
      wlow = 0;
      sc = 0;
    end
    dq_in <= (ast >= T_AA && olc >= T_OA) ? pin_mem[sram_addr] : 8'hEE;
    prev_addr = sram_addr;
    prev_we_n = we_n;
    prev_ce_n = ce_n;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && done) begin
    if (sb.size() == 0) check(1'b0, "R6 done without request", 1, 0);
    else begin
      item_t it;
      it = sb.pop_front();
      if (!it.wr) check(rd_data == it.data, "R5 R6 read data", rd_data, it.data);
      else        check(1'b1, "R6 write done", 1, 1);
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int busy;
    item_t it;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    it.wr = wr;
    it.data = wr ? d : exp_mem[a];
    if (wr) exp_mem[a] = d;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
    check(busy == busy_cycles(wr), "R7 busy length", busy, busy_cycles(wr));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      pin_mem[i] = DW'(i) ^ 8'h5A;
      exp_mem[i] = DW'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    check(req_ready && ce_n && oe_n && we_n && !dq_oe && !done, "R9 reset state",
          {req_ready, ce_n, oe_n, we_n, dq_oe, done}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b0, 11'h010, 8'h00);          // R5 initial content
    issue(1'b1, 11'h010, 8'hA5);          // R2 R4
    issue(1'b0, 11'h010, 8'h00);          // read after write
    issue(1'b1, 11'h7FF, 8'hFF);          // top address
    issue(1'b1, 11'h000, 8'h00);          // bottom address
    issue(1'b0, 11'h7FF, 8'h00);
    issue(1'b0, 11'h000, 8'h00);
    // R8: request held while busy must be ignored
    fork
      issue(1'b1, 11'h123, 8'h3C);
      begin
        repeat (2) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h456; req_wdata = 8'hC3;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    issue(1'b0, 11'h456, 8'h00);          // R8 untouched
    issue(1'b0, 11'h123, 8'h00);
    for (int k = 0; k < 6; k++) begin     // R1 mixed traffic
      issue(1'b1, AW'(k * 97 + 5), DW'(k * 37 + 1));
      issue(1'b0, AW'(k * 97 + 5), 8'h00);
    end
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R6 all requests completed", sb.size(), 0);
    summary();
  end

endmodule